// File: doc/BRIEF.md
# Serial Single-Letter Command Handler

This block sits between a UART receiver, a UART transmitter and a byte-storage pointer unit. It takes received characters one at a time and treats six uppercase letters as commands. A command can answer with a ready character, push a self-advancing test letter into storage, pop one stored byte back out, dump the stored bytes, report the write pointer as hexadecimal text, or raise a one-cycle display-refresh request. Every other character is discarded. The block runs one command at a time. It ignores received characters until the running command has finished.

Reply bytes go out through a valid/ready pair, and each byte is held until the transmitter takes it. Storage operations use a request/acknowledge pair. An operation code selects push, pop or read-at-address. A read returns a byte on the same cycle as its acknowledge. The pointer unit also drives its current write pointer into the block. The dump uses this pointer as its end bound, and the hex report prints it.

The controller is a single state machine:
- IDLE waits for a command.
- ECHO sends the ready character.
- PUSH pushes the test letter into storage.
- POP pops a byte from storage. POP_TX then sends that byte.
- DUMP_CHK compares the dump address with the bound. DUMP_RD reads one byte. DUMP_TX sends it.
- HEX_TX sends the hex digits. SPACE_TX sends the trailing space.
- FLASH is a one-cycle refresh state.

The transitions are:
- IDLE goes to the state chosen by an accepted command letter, or stays in IDLE.
- ECHO, POP_TX and SPACE_TX go back to IDLE on a transmit handshake.
- PUSH goes to IDLE on acknowledge. POP goes to POP_TX on acknowledge.
- DUMP_CHK goes to IDLE when the address reaches the bound, and to DUMP_RD otherwise.
- DUMP_RD goes to DUMP_TX on acknowledge. DUMP_TX goes back to DUMP_CHK on a transmit handshake.
- HEX_TX repeats until the last digit has been taken, then goes to SPACE_TX.
- FLASH always goes to IDLE.

Top module: `serial_cmd_handler`

## Requirements
- R1: A received 0x41 ('A') causes exactly one transmitted byte, 0x59 ('Y').
- R2: A received 0x42 ('B') captures the write pointer P. It then reads addresses 0, 1, … P-1 in ascending order with op code 2 and transmits each returned byte unchanged, in order. If P is 0, no storage request and no byte follow.
- R3: A received 0x43 ('C') captures the write pointer. It transmits that value as AW/4 ASCII hex digits, most significant digit first, and then 0x20. Each digit is its nibble plus 0x30, plus a further 7 when that sum exceeds 0x39. The result is the uppercase digits 0-9 and A-F.
- R4: A received 0x44 ('D') pushes the test letter with op code 0 as the write data. After the acknowledge, the letter advances by one. After 0x7A ('z') it returns to 0x41 ('A'). It starts at 0x41 after reset.
- R5: A received 0x45 ('E') issues a pop with op code 1. It transmits the acknowledged read byte unchanged.
- R6: A received 0x46 ('F') drives refresh_pulse high for exactly one clock cycle. No byte is transmitted and no storage request is made.
- R7: Any other received value produces no transmitted byte, no storage request and no refresh pulse.
- R8: A byte is transferred on a rising edge where tx_valid and tx_ready are both high. While tx_ready is low, tx_valid stays high and tx_data does not change.
- R9: mem_req stays high with mem_op, mem_addr and mem_wdata unchanged until an edge where mem_ack is high. That edge completes the operation.
- R10: A received byte is taken only while the block is idle. Bytes that arrive while a command is running are dropped and have no effect.
- R11: During reset, tx_valid, mem_req and refresh_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | Reply byte offered to the transmitter |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| mem_req | output | 1 | Storage operation requested |
| mem_op | output | 2 | 0 push, 1 pop, 2 read at mem_addr |
| mem_addr | output | AW | Address for a read-at-address |
| mem_wdata | output | 8 | Byte to push |
| mem_ack | input | 1 | Storage operation completes at this edge |
| mem_rdata | input | 8 | Byte returned with mem_ack for pop or read |
| wr_ptr | input | AW | Current write pointer of the storage unit |
| refresh_pulse | output | 1 | One-cycle display-refresh request |

## Verification
The assertions assume the following about the inputs:
- tx_ready and mem_ack behave as handshake partners.
- mem_ack is raised only while mem_req is high.
- wr_ptr does not move while a dump is running.

The stimulus meets these assumptions with a pointer-unit model. It raises acknowledge only when it sees a request, it changes the pointer only on an acknowledged push, and it changes the forced pointer values only between commands. The ready and acknowledge lines alternate between always-high and pseudo-random stalling, so both the hold rule and the fast path are covered.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ECHO,
        S_PUSH,
        S_POP,
        S_POP_TX,
        S_DUMP_CHK,
        S_DUMP_RD,
        S_DUMP_TX,
        S_HEX_TX,
        S_SPACE_TX,
        S_FLASH
    } scmd_state_e;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_READ = 2'd2
    } scmd_op_e;

    localparam logic [7:0] CMD_ECHO   = 8'h41;
    localparam logic [7:0] CMD_DUMP   = 8'h42;
    localparam logic [7:0] CMD_PTR    = 8'h43;
    localparam logic [7:0] CMD_PUSH   = 8'h44;
    localparam logic [7:0] CMD_POP    = 8'h45;
    localparam logic [7:0] CMD_FLASH  = 8'h46;
    localparam logic [7:0] CH_READY   = 8'h59;
    localparam logic [7:0] CH_SPACE   = 8'h20;
    localparam logic [7:0] LET_FIRST  = 8'h41;
    localparam logic [7:0] LET_LAST   = 8'h7A;

    function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
        logic [7:0] s;
        s = {4'h0, nib} + 8'h30;
        if (s > 8'h39) begin
            s = s + 8'd7;
        end
        return s;
    endfunction

endpackage

// File: rtl/scmd_letter_gen.sv
module scmd_letter_gen
    import scmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    output logic [7:0] letter
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            letter <= LET_FIRST;
        end else if (adv) begin
            letter <= (letter == LET_LAST) ? LET_FIRST : letter + 8'd1;
        end
    end

    // R4: the letter never leaves the 'A'..'z' window
    a_r4_letter_range: assert property (@(posedge clk) disable iff (!rst_n)
        (letter >= LET_FIRST) && (letter <= LET_LAST));

    // R4: the letter moves only when a push completes
    a_r4_letter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(letter));

endmodule

// File: rtl/scmd_hex_sel.sv
module scmd_hex_sel
    import scmd_pkg::*;
#(
    parameter int AW = 24,
    parameter int IW = 3
) (
    input  logic [AW-1:0] value,
    input  logic [IW-1:0] idx,
    output logic [7:0]    ascii
);

    localparam int NDIG = AW / 4;

    logic [3:0]    nibs [NDIG];
    logic [IW-1:0] sel;

    for (genvar g = 0; g < NDIG; g++) begin : g_nib
        assign nibs[g] = value[4*g +: 4];
    end

    // digit 0 is the most significant nibble
    assign sel   = IW'(NDIG - 1) - idx;
    assign ascii = nib_to_ascii(nibs[sel]);

endmodule

// File: rtl/serial_cmd_handler.sv
module serial_cmd_handler
    import scmd_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    input  logic [AW-1:0] wr_ptr,
    output logic          refresh_pulse
);

    localparam int NDIG = AW / 4;
    localparam int IW   = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [IW-1:0] DIG_LAST = IW'(NDIG - 1);

    scmd_state_e   state_q, state_d;
    logic [7:0]    byte_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] addr_q;
    logic [IW-1:0] dig_q;
    logic [7:0]    letter;
    logic [7:0]    hex_char;
    logic          take_cmd;
    logic          letter_adv;

    assign take_cmd   = (state_q == S_IDLE) && rx_valid;
    assign letter_adv = (state_q == S_PUSH) && mem_ack;

    scmd_letter_gen u_letter (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (letter_adv),
        .letter (letter)
    );

    scmd_hex_sel #(.AW(AW), .IW(IW)) u_hex (
        .value (ptr_q),
        .idx   (dig_q),
        .ascii (hex_char)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rx_valid) begin
                    case (rx_data)
                        CMD_ECHO:  state_d = S_ECHO;
                        CMD_DUMP:  state_d = S_DUMP_CHK;
                        CMD_PTR:   state_d = S_HEX_TX;
                        CMD_PUSH:  state_d = S_PUSH;
                        CMD_POP:   state_d = S_POP;
                        CMD_FLASH: state_d = S_FLASH;
                        default:   state_d = S_IDLE;
                    endcase
                end
            end
            S_ECHO:     if (tx_ready) state_d = S_IDLE;
            S_PUSH:     if (mem_ack)  state_d = S_IDLE;
            S_POP:      if (mem_ack)  state_d = S_POP_TX;
            S_POP_TX:   if (tx_ready) state_d = S_IDLE;
            S_DUMP_CHK: state_d = (addr_q == ptr_q) ? S_IDLE : S_DUMP_RD;
            S_DUMP_RD:  if (mem_ack)  state_d = S_DUMP_TX;
            S_DUMP_TX:  if (tx_ready) state_d = S_DUMP_CHK;
            S_HEX_TX:   if (tx_ready) state_d = (dig_q == DIG_LAST) ? S_SPACE_TX : S_HEX_TX;
            S_SPACE_TX: if (tx_ready) state_d = S_IDLE;
            S_FLASH:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            ptr_q  <= '0;
            addr_q <= '0;
            dig_q  <= '0;
        end else begin
            if (take_cmd && (rx_data == CMD_DUMP || rx_data == CMD_PTR)) begin
                ptr_q  <= wr_ptr;
                addr_q <= '0;
                dig_q  <= '0;
            end
            if ((state_q == S_POP || state_q == S_DUMP_RD) && mem_ack) begin
                byte_q <= mem_rdata;
            end
            if (state_q == S_DUMP_TX && tx_ready) begin
                addr_q <= addr_q + 1'b1;
            end
            if (state_q == S_HEX_TX && tx_ready && dig_q != DIG_LAST) begin
                dig_q <= dig_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid      = 1'b0;
        tx_data       = '0;
        mem_req       = 1'b0;
        mem_op        = OP_PUSH;
        mem_addr      = '0;
        mem_wdata     = '0;
        refresh_pulse = 1'b0;
        unique case (state_q)
            S_ECHO: begin
                tx_valid = 1'b1;
                tx_data  = CH_READY;
            end
            S_PUSH: begin
                mem_req   = 1'b1;
                mem_op    = OP_PUSH;
                mem_wdata = letter;
            end
            S_POP: begin
                mem_req = 1'b1;
                mem_op  = OP_POP;
            end
            S_DUMP_RD: begin
                mem_req  = 1'b1;
                mem_op   = OP_READ;
                mem_addr = addr_q;
            end
            S_POP_TX, S_DUMP_TX: begin
                tx_valid = 1'b1;
                tx_data  = byte_q;
            end
            S_HEX_TX: begin
                tx_valid = 1'b1;
                tx_data  = hex_char;
            end
            S_SPACE_TX: begin
                tx_valid = 1'b1;
                tx_data  = CH_SPACE;
            end
            S_FLASH: refresh_pulse = 1'b1;
            default: ;
        endcase
    end

    // R8: an offered byte waits, unchanged, for the transmitter
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R9: a storage request holds its fields until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_op)
                                && $stable(mem_addr) && $stable(mem_wdata));

    // R6: the refresh request never lasts two cycles
    a_r6_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |=> !refresh_pulse);

    // R10: one command at a time, so at most one activity is visible
    a_r10_single_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tx_valid, mem_req, refresh_pulse}) <= 1);

    // R3: pointer digits are uppercase hex characters
    a_r3_hex_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HEX_TX) |-> ((tx_data >= 8'h30 && tx_data <= 8'h39) ||
                                   (tx_data >= 8'h41 && tx_data <= 8'h46)));

endmodule

// File: tb/sim_serial_cmd_handler.sv
module sim_serial_cmd_handler;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 24;
    localparam int MEMN       = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b0;
    logic          mem_req;
    logic [1:0]    mem_op;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic [AW-1:0] wp = '0;
    logic          refresh_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_handler #(.AW(AW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .tx_ready      (tx_ready),
        .mem_req       (mem_req),
        .mem_op        (mem_op),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .wr_ptr        (wp),
        .refresh_pulse (refresh_pulse)
    );

    int         n_checks = 0;
    int         n_fail = 0;
    logic [7:0] mem_m [MEMN];
    int         rd_m = 0;
    logic [7:0] expq [1024];
    int         eh = 0;
    int         et = 0;
    string      tag = "R11";
    int         tx_cnt = 0;
    int         pulse_cnt = 0;
    int         push_cnt = 0;
    int         memop_cnt = 0;
    logic       prev_pulse = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int         rdy_mode = 0;
    int         ack_mode = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input int b);
        expq[et] = b[7:0];
        et++;
    endtask

    task automatic push_hex(input logic [AW-1:0] v);
        for (int i = AW/4 - 1; i >= 0; i--) begin
            int d;
            d = int'((v >> (4*i)) & 24'hF);
            push_exp(d < 10 ? 48 + d : 55 + d);
        end
        push_exp(32);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int q;
        q = 0;
        for (int i = 0; i < 5000 && q < 4; i++) begin
            @(negedge clk);
            #1;
            if (eh == et && !tx_valid && !mem_req) q++;
            else q = 0;
        end
    endtask

    // pointer-unit and transmitter model; also the output monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            tx_ready = 1'b0;
            mem_ack  = 1'b0;
        end else begin
            logic rdy;
            logic ack;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (refresh_pulse) begin
                if (prev_pulse) check(1'b0, "R6 pulse width", 2, 1);
                pulse_cnt++;
            end
            prev_pulse = refresh_pulse;
            rdy = (rdy_mode == 0) ? 1'b1 : lfsr[0];
            if (tx_valid && rdy) begin
                tx_cnt++;
                if (eh == et) begin
                    check(1'b0, {tag, " unexpected byte"}, tx_data, 0);
                end else begin
                    check(tx_data == expq[eh], tag, tx_data, expq[eh]);
                    eh++;
                end
            end
            tx_ready  = rdy;
            ack       = mem_req && ((ack_mode == 0) ? 1'b1 : lfsr[3]);
            mem_rdata = '0;
            if (ack) begin
                memop_cnt++;
                case (mem_op)
                    2'd0: begin
                        check(mem_wdata == 8'(65 + (push_cnt % 58)), "R4 pushed letter",
                              mem_wdata, 65 + (push_cnt % 58));
                        mem_m[wp[5:0]] = mem_wdata;
                        wp = wp + 1'b1;
                        push_cnt++;
                    end
                    2'd1: begin
                        mem_rdata = mem_m[rd_m % MEMN];
                        rd_m++;
                    end
                    2'd2: mem_rdata = mem_m[mem_addr[5:0]];
                    default: check(1'b0, "R9 op code", mem_op, 0);
                endcase
            end
            mem_ack = ack;
        end
    end

    initial begin
        int t0, m0, p0;
        repeat (3) @(negedge clk);
        check(!tx_valid && !mem_req && !refresh_pulse, "R11 outputs in reset",
              {tx_valid, mem_req, refresh_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!tx_valid && !mem_req && !refresh_pulse, "R11 outputs after reset",
              {tx_valid, mem_req, refresh_pulse}, 0);

        // R2: empty dump
        tag = "R2 empty dump";
        m0 = memop_cnt; t0 = tx_cnt;
        send_cmd(8'h42);
        wait_quiet();
        check(memop_cnt == m0 && tx_cnt == t0, "R2 empty dump silent", memop_cnt - m0, 0);

        // R1 with steady then stalling transmitter (R8)
        tag = "R1 ready char";
        push_exp(8'h59);
        send_cmd(8'h41);
        wait_quiet();
        rdy_mode = 1;
        tag = "R8 stalled ready char";
        for (int k = 0; k < 3; k++) begin
            push_exp(8'h59);
            send_cmd(8'h41);
            wait_quiet();
        end
        check(eh == et, "R8 all bytes delivered", eh, et);
        rdy_mode = 0;

        // R10: second byte arriving one cycle later is dropped
        tag = "R10 busy drop";
        push_exp(8'h59);
        p0 = pulse_cnt; t0 = tx_cnt;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h41;
        @(negedge clk);
        rx_data = 8'h46;
        @(negedge clk);
        rx_valid = 1'b0;
        wait_quiet();
        check(pulse_cnt == p0 && tx_cnt == t0 + 1, "R10 busy byte dropped", pulse_cnt - p0, 0);

        // R7: every non-command code
        tag = "R7 ignored";
        for (int c = 0; c < 256; c++) begin
            if (c < 65 || c > 70) begin
                t0 = tx_cnt; m0 = memop_cnt; p0 = pulse_cnt;
                send_cmd(8'(c));
                wait_quiet();
                check(tx_cnt == t0 && memop_cnt == m0 && pulse_cnt == p0,
                      "R7 code ignored", c, 0);
            end
        end

        // R6: refresh pulse
        tag = "R6 refresh";
        p0 = pulse_cnt; t0 = tx_cnt; m0 = memop_cnt;
        send_cmd(8'h46);
        wait_quiet();
        check(pulse_cnt == p0 + 1, "R6 one pulse", pulse_cnt - p0, 1);
        check(tx_cnt == t0 && memop_cnt == m0, "R6 no other activity", tx_cnt - t0, 0);

        // R4: sixty pushes cross the 'z' wrap, stalling acknowledge (R9)
        ack_mode = 1;
        tag = "R4 push";
        for (int k = 0; k < 60; k++) begin
            send_cmd(8'h44);
            wait_quiet();
        end
        check(push_cnt == 60, "R4 push count", push_cnt, 60);
        check(wp == 24'd60, "R9 pointer advanced", int'(wp), 60);

        // R3: pointer report
        rdy_mode = 1;
        tag = "R3 pointer hex";
        push_hex(wp);
        send_cmd(8'h43);
        wait_quiet();
        check(eh == et, "R3 report complete", eh, et);

        // R2: full dump with a D arriving mid-way (R10)
        tag = "R2 dump";
        for (int a = 0; a < 60; a++) push_exp(65 + (a % 58));
        m0 = push_cnt;
        send_cmd(8'h42);
        repeat (30) @(negedge clk);
        send_cmd(8'h44);
        wait_quiet();
        check(eh == et, "R2 dump complete", eh, et);
        check(push_cnt == m0, "R10 push during dump dropped", push_cnt, m0);

        // R5: pops
        tag = "R5 pop";
        for (int k = 0; k < 3; k++) begin
            push_exp(65 + k);
            send_cmd(8'h45);
            wait_quiet();
        end
        check(eh == et, "R5 pops delivered", eh, et);

        // R3: every nibble value in several digit positions
        begin
            logic [AW-1:0] vals [4];
            logic [AW-1:0] keep;
            vals[0] = 24'h012345; vals[1] = 24'h6789AB;
            vals[2] = 24'hCDEF09; vals[3] = 24'hFEDCBA;
            keep = wp;
            tag = "R3 hex sweep";
            for (int k = 0; k < 4; k++) begin
                wp = vals[k];
                push_hex(vals[k]);
                send_cmd(8'h43);
                wait_quiet();
            end
            wp = keep;
        end
        check(eh == et, "R3 sweep complete", eh, et);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule